// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Guard

This block sits between the bus-side write decoder and the page programming engine of a byte-wide non-volatile array. Every internal write request (strobe, address, data byte) passes through it. By default all writes are blocked. A write reaches the array only after the host has issued three fixed command writes in order. The first puts 0xAA at 0x5555, the second puts 0x55 at 0x2AAA and the third puts 0xA0 at 0x5555. None of the command writes is itself passed on.

After the third command byte, the guard is open. Each data write that follows is forwarded to the programming engine with a one-cycle registered delay. An external byte-load timer raises a window-expired flag when the gap since the last accepted byte is too long. If that happens during the command bytes, the attempt is abandoned. If it happens after data has been loaded, the guard closes and holds every write off until the engine reports that its internal write cycle is done. Protection then re-arms by itself.

The `unlocked` output shows whether the guard is currently open. It is intended for observation.

Top module: `wp_unlock_guard`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `unlocked` and `fwd_we` are both 0.
- R2: A strobe accepted while `unlocked` is 0 is never forwarded, and `fwd_we` does not rise for it.
- R3: The guard opens only after three consecutive accepted strobes carrying address/data 0x5555/0xAA, then 0x2AAA/0x55, then 0x5555/0xA0. `unlocked` reads 1 from the clock edge that samples the third strobe. None of the three is forwarded.
- R4: A strobe whose address or data does not match the expected command byte sends the detector back to its first step and is discarded. The sequence must then restart from 0x5555/0xAA.
- R5: `win_expired` while the detector is part way through the command bytes abandons the attempt. The remaining command bytes then do not open the guard.
- R6: While `unlocked` is 1, each strobe sets `fwd_we` high for exactly the next cycle, with `fwd_addr`/`fwd_data` equal to the strobe's address and data.
- R7: `win_expired` while unlocked after at least one data write closes the guard. From then until `wcyc_done` is seen, every strobe (command bytes included) is ignored. After `wcyc_done`, a new command sequence opens the guard again.
- R8: `win_expired` while unlocked with no data written closes the guard. A new command sequence is accepted at once, without waiting for `wcyc_done`.
- R9: A strobe in the same cycle as `win_expired` is discarded in every state and is never forwarded.
- R10: `wcyc_done` while the guard is open or locked-idle has no effect. An open guard stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle internal write request |
| wr_addr | input | AW (15) | Write address |
| wr_data | input | DW (8) | Write data byte |
| win_expired | input | 1 | Byte-load window elapsed since the last accepted byte |
| wcyc_done | input | 1 | Internal programming cycle finished |
| fwd_we | output | 1 | Registered write enable to the page engine |
| fwd_addr | output | AW (15) | Registered forwarded address |
| fwd_data | output | DW (8) | Registered forwarded data |
| unlocked | output | 1 | Guard open (data writes pass) |

## Verification
Every input is sampled on a rising edge. The state change it causes, and so `unlocked`, is visible from that edge on. A forwarded write appears on `fwd_we`/`fwd_addr`/`fwd_data` during the cycle that follows the sampling edge, one register deep. The bench drives on falling edges and checks `unlocked` at the falling edge right after the sampling edge. A monitor compares each `fwd_we` pulse at the next falling edge against a queue that the driver fills only for writes the requirements say must pass. Any extra pulse, and any entry still queued at the end, is a miscompare.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_OPEN   = 2'd1,
    ST_BUSY   = 2'd2
  } wpu_state_e;
endpackage

// File: rtl/wpu_key_match.sv
module wpu_key_match #(
  parameter int AW   = 15,
  parameter int DW   = 8,
  parameter int KEYS = 3,
  parameter int SW   = 2,
  parameter logic [KEYS-1:0][AW-1:0] KEY_ADDR = '0,
  parameter logic [KEYS-1:0][DW-1:0] KEY_DATA = '0
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [SW-1:0] step,
  output logic          key_ok
);
  logic [KEYS-1:0] hit;

  for (genvar k = 0; k < KEYS; k++) begin : g_key
    assign hit[k] = (addr == KEY_ADDR[k]) && (data == KEY_DATA[k]);
  end

  always_comb begin
    key_ok = 1'b0;
    for (int k = 0; k < KEYS; k++) begin
      if (step == SW'(k)) key_ok = hit[k];
    end
  end
endmodule

// File: rtl/wpu_seq_ctrl.sv
module wpu_seq_ctrl
  import wpu_pkg::*;
#(
  parameter int KEYS = 3,
  parameter int SW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic          win_expired,
  input  logic          wcyc_done,
  input  logic          key_ok,
  output logic [SW-1:0] step,
  output logic          pass_en,
  output logic          unlocked
);
  localparam logic [SW-1:0] LAST_STEP = SW'(KEYS - 1);

  wpu_state_e state;
  logic       had_data;

  assign pass_en = (state == ST_OPEN) && wr_stb && !win_expired;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_LOCKED;
      step     <= '0;
      had_data <= 1'b0;
      unlocked <= 1'b0;
    end else begin
      case (state)
        ST_LOCKED: begin
          if (win_expired) begin
            step <= '0;
          end else if (wr_stb) begin
            if (!key_ok) begin
              step <= '0;
            end else if (step == LAST_STEP) begin
              state    <= ST_OPEN;
              step     <= '0;
              had_data <= 1'b0;
              unlocked <= 1'b1;
            end else begin
              step <= step + 1'b1;
            end
          end
        end
        ST_OPEN: begin
          if (win_expired) begin
            unlocked <= 1'b0;
            state    <= had_data ? ST_BUSY : ST_LOCKED;
          end else if (wr_stb) begin
            had_data <= 1'b1;
          end
        end
        ST_BUSY: begin
          if (wcyc_done) state <= ST_LOCKED;
        end
        default: begin
          state    <= ST_LOCKED;
          unlocked <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/wpu_fwd_reg.sv
module wpu_fwd_reg #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pass_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          fwd_we,
  output logic [AW-1:0] fwd_addr,
  output logic [DW-1:0] fwd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_we   <= 1'b0;
      fwd_addr <= '0;
      fwd_data <= '0;
    end else begin
      fwd_we <= pass_en;
      if (pass_en) begin
        fwd_addr <= addr;
        fwd_data <= data;
      end
    end
  end
endmodule

// File: rtl/wp_unlock_guard.sv
module wp_unlock_guard #(
  parameter int AW   = 15,
  parameter int DW   = 8,
  parameter int KEYS = 3,
  parameter logic [KEYS-1:0][AW-1:0] KEY_ADDR = {15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [KEYS-1:0][DW-1:0] KEY_DATA = {8'hA0, 8'h55, 8'hAA}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          win_expired,
  input  logic          wcyc_done,
  output logic          fwd_we,
  output logic [AW-1:0] fwd_addr,
  output logic [DW-1:0] fwd_data,
  output logic          unlocked
);
  localparam int SW = (KEYS > 1) ? $clog2(KEYS) : 1;

  logic [SW-1:0] step;
  logic          key_ok;
  logic          pass_en;

  wpu_key_match #(
    .AW(AW), .DW(DW), .KEYS(KEYS), .SW(SW),
    .KEY_ADDR(KEY_ADDR), .KEY_DATA(KEY_DATA)
  ) i_match (
    .addr(wr_addr), .data(wr_data), .step(step), .key_ok(key_ok)
  );

  wpu_seq_ctrl #(.KEYS(KEYS), .SW(SW)) i_ctrl (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .win_expired(win_expired),
    .wcyc_done(wcyc_done), .key_ok(key_ok), .step(step),
    .pass_en(pass_en), .unlocked(unlocked)
  );

  wpu_fwd_reg #(.AW(AW), .DW(DW)) i_fwd (
    .clk(clk), .rst(rst), .pass_en(pass_en), .addr(wr_addr), .data(wr_data),
    .fwd_we(fwd_we), .fwd_addr(fwd_addr), .fwd_data(fwd_data)
  );
endmodule

// File: rtl/wpu_guard_chk.sv
module wpu_guard_chk #(
  parameter int AW   = 15,
  parameter int DW   = 8,
  parameter int KEYS = 3,
  parameter logic [KEYS-1:0][AW-1:0] KEY_ADDR = '0,
  parameter logic [KEYS-1:0][DW-1:0] KEY_DATA = '0
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_stb,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          win_expired,
  input logic          fwd_we,
  input logic [AW-1:0] fwd_addr,
  input logic [DW-1:0] fwd_data,
  input logic          unlocked
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!unlocked && !fwd_we));

  // R2
  fwd_only_open_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_we |-> $past(unlocked));

  // R6
  fwd_payload_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_we |-> ($past(wr_stb) && fwd_addr == $past(wr_addr) && fwd_data == $past(wr_data)));

  // R9
  expired_drop_chk: assert property (@(posedge clk) disable iff (rst)
    win_expired |=> !fwd_we);

  // R3
  open_on_last_key_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> ($past(wr_stb) && $past(wr_addr) == KEY_ADDR[KEYS-1]
                         && $past(wr_data) == KEY_DATA[KEYS-1]));

  // R7
  expire_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (unlocked && win_expired) |=> !unlocked);

  // R10
  open_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (unlocked && !win_expired) |=> unlocked);
endmodule

bind wp_unlock_guard wpu_guard_chk #(
  .AW(AW), .DW(DW), .KEYS(KEYS), .KEY_ADDR(KEY_ADDR), .KEY_DATA(KEY_DATA)
) i_guard_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
  .win_expired(win_expired), .fwd_we(fwd_we), .fwd_addr(fwd_addr),
  .fwd_data(fwd_data), .unlocked(unlocked)
);

// File: tb/test_wp_unlock_guard.sv
`timescale 1ns/1ps
module test_wp_unlock_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        win_expired = 1'b0;
  logic        wcyc_done = 1'b0;
  logic        fwd_we;
  logic [14:0] fwd_addr;
  logic [7:0]  fwd_data;
  logic        unlocked;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;
  logic [22:0] exp_q[$];

  always #2.5 clk = ~clk;

  wp_unlock_guard i_wp_unlock_guard (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_expired(win_expired), .wcyc_done(wcyc_done), .fwd_we(fwd_we),
    .fwd_addr(fwd_addr), .fwd_data(fwd_data), .unlocked(unlocked)
  );

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input bit exp_fwd);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    if (exp_fwd) exp_q.push_back({a, d});
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wr_exp(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d; win_expired = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; win_expired = 1'b0;
  endtask

  task automatic expire();
    @(negedge clk); win_expired = 1'b1;
    @(negedge clk); win_expired = 1'b0;
  endtask

  task automatic cyc_done();
    @(negedge clk); wcyc_done = 1'b1;
    @(negedge clk); wcyc_done = 1'b0;
  endtask

  task automatic unlock_seq();
    wr(15'h5555, 8'hAA, 0);
    wr(15'h2AAA, 8'h55, 0);
    wr(15'h5555, 8'hA0, 0);
  endtask

  task automatic chk_unl(input logic exp, input string tag);
    n_chk++;
    if (unlocked !== exp) begin
      n_fail++;
      $display("FAIL %s unlocked=%0b expected %0b", tag, unlocked, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each forwarded write (R2, R6)
  always @(negedge clk) begin
    if (!rst && fwd_we) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected forward addr=%h data=%h expected none",
                 fwd_addr, fwd_data);
      end else begin
        logic [22:0] e;
        e = exp_q.pop_front();
        if ({fwd_addr, fwd_data} !== e) begin
          n_fail++;
          $display("FAIL R6 forward addr/data=%h/%h expected %h/%h",
                   fwd_addr, fwd_data, e[22:8], e[7:0]);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired unlocked=%0b expected run end", unlocked);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_unl(1'b0, "R1");
    n_chk++;
    if (fwd_we !== 1'b0) begin
      n_fail++; $display("FAIL R1 fwd_we=%0b expected 0", fwd_we);
    end
    rst = 1'b0;
    @(negedge clk);
    chk_unl(1'b0, "R1");

    // R2: locked write discarded
    wr(15'h1234, 8'h5A, 0);
    chk_unl(1'b0, "R2");

    // R3: full unlock, commands not forwarded
    wr(15'h5555, 8'hAA, 0); chk_unl(1'b0, "R3");
    wr(15'h2AAA, 8'h55, 0); chk_unl(1'b0, "R3");
    wr(15'h5555, 8'hA0, 0); chk_unl(1'b1, "R3");

    // R6: data writes forwarded
    wr(15'h5500, 8'h11, 1);
    wr(15'h557F, 8'h22, 1);
    chk_unl(1'b1, "R6");

    // R7: close after data, busy until done
    expire();
    chk_unl(1'b0, "R7");
    unlock_seq();
    chk_unl(1'b0, "R7");
    wr(15'h0001, 8'h77, 0);
    cyc_done();
    unlock_seq();
    chk_unl(1'b1, "R7");

    // R10: done while open has no effect
    cyc_done();
    chk_unl(1'b1, "R10");

    // R8: close with no data, reopen at once
    expire();
    chk_unl(1'b0, "R8");
    unlock_seq();
    chk_unl(1'b1, "R8");
    expire();

    // R10: done while locked idle, sequence still works
    cyc_done();
    unlock_seq();
    chk_unl(1'b1, "R10");
    expire();

    // R4: data mismatch at step 2, then partial retry
    wr(15'h5555, 8'hAA, 0);
    wr(15'h2AAA, 8'h54, 0);
    wr(15'h5555, 8'hA0, 0);
    chk_unl(1'b0, "R4");
    wr(15'h2AAA, 8'h55, 0);
    wr(15'h5555, 8'hA0, 0);
    chk_unl(1'b0, "R4");
    // R4: address mismatch at step 3
    wr(15'h5555, 8'hAA, 0);
    wr(15'h2AAA, 8'h55, 0);
    wr(15'h5554, 8'hA0, 0);
    chk_unl(1'b0, "R4");

    // R5: expiry mid sequence
    wr(15'h5555, 8'hAA, 0);
    expire();
    wr(15'h2AAA, 8'h55, 0);
    wr(15'h5555, 8'hA0, 0);
    chk_unl(1'b0, "R5");

    // R9: strobe with expiry during command bytes
    wr(15'h5555, 8'hAA, 0);
    wr_exp(15'h2AAA, 8'h55);
    wr(15'h5555, 8'hA0, 0);
    chk_unl(1'b0, "R9");

    // R9: strobe with expiry while open is dropped
    unlock_seq();
    chk_unl(1'b1, "R9");
    wr_exp(15'h0100, 8'h33);
    chk_unl(1'b0, "R9");
    unlock_seq();
    chk_unl(1'b1, "R9");
    wr(15'h0200, 8'h44, 1);
    expire();
    cyc_done();
    repeat (3) @(negedge clk);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R6 pending forwards=%0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule